// File: doc/BRIEF.md
# Chained Transmit Descriptor Walker

This block is the transmit-side DMA engine of an Ethernet-style MAC. It follows a linked list of transmit descriptors in system memory. Each descriptor has four 32-bit words. The engine reads the descriptor and checks its owner flag. If the engine owns it, the engine reads the buffer and sends it out one byte per beat on a valid/ready stream with start-of-frame and end-of-frame markers. It then writes the status word back so that the descriptor returns to the host. It then moves on to the next descriptor, either through the descriptor's own link word or to the next sequential slot.

Software controls the engine through a write-only register port. The port has a list base, a run bit and a poll-demand register, plus a self-clearing soft reset. When the engine meets a descriptor the host still owns, it parks and raises a sticky "no descriptor available" flag. It does not look at memory again until software writes the poll-demand register. A frame may span several descriptors. The first and last segment flags in each control word decide where the frame markers go.

Top module: `txdesc_dma`

## Requirements
- R1: After reset, `tx_valid`, `mem_req` and `tx_unavail` are 0 and the engine is stopped.
- R2: A descriptor at pointer P is read as four words: status at P, control at P+4, buffer address at P+8, link at P+12. The byte count is control bits 10:0. The status word is always read first.
- R3: If the status word read has bit 31 (owner) at 0, the engine reads nothing further and emits no byte. It parks and sets `tx_unavail`. `tx_unavail` stays 1, including across later resumes, until a soft reset.
- R4: Any write to register offset 0x04 (poll demand), whatever its data, makes a parked engine read the status word at its current pointer again.
- R5: An owned descriptor emits exactly its byte-count bytes, taken from consecutive byte addresses starting at the buffer address. The buffer may start at any alignment. Within each 32-bit memory word, the byte at the lowest address is in bits 7:0. A count of 0 emits no byte.
- R6: `tx_sof` is 1 only on the first byte of a descriptor whose control bit 29 is 1. `tx_eof` is 1 only on the last byte of a descriptor whose control bit 30 is 1.
- R7: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data`, `tx_sof` and `tx_eof` hold their values.
- R8: After the last byte of a descriptor is accepted, the engine does exactly one memory write, to the status word. The value written has bit 31 at 0, bits 16:0 at 0, and bits 30:17 as read. No byte is emitted while that write is pending.
- R9: After the write-back, the next pointer is the link word if control bit 24 is 1, and P+16 otherwise.
- R10: A memory request (`mem_req`) keeps `mem_we`, `mem_addr` and `mem_wdata` stable until the cycle in which `mem_ack` is 1.
- R11: Writing 1 to bit 0 of offset 0x00 (soft reset) stops the engine at once, drops any pending request and any unsent bytes, clears the run bit and `tx_unavail`, and reloads the pointer from the list base. A write to offset 0x10 always updates the list base, but it loads the pointer only while the engine is stopped.
- R12: Bit 13 of offset 0x18 is the run bit. The engine fetches only while run is 1. If run is cleared, the engine stops once it has finished the descriptor in progress, or at once if it is parked. When run is set again, it resumes at its current pointer, not at the list base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_unavail | output | 1 | Sticky: a host-owned descriptor was met |

## Verification
Two events can coincide. One is the status write-back of a descriptor. The other is its byte stream, which has been slowed by back-pressure. The write must not start while the last byte is still held by a stalled sink. The bench stalls `tx_ready` on a pseudo-random pattern across a multi-descriptor frame with unaligned buffers. The scoreboard then confirms that every byte and marker arrives in order. The write-back words in memory are checked afterwards, and a property forbids a pending write while a byte is valid. A second overlap is a soft reset that lands while the engine is parked or active. The bench checks that the reset clears the sticky flag and any request in the same step, and that nothing is fetched until run is set again.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned OFS_BUS   = 'h00;
   localparam int unsigned OFS_POLL  = 'h04;
   localparam int unsigned OFS_BASE  = 'h10;
   localparam int unsigned OFS_OPER  = 'h18;
   localparam int unsigned BIT_SRST  = 0;
   localparam int unsigned BIT_RUN   = 13;
   localparam int unsigned BIT_OWN   = 31;
   localparam int unsigned BIT_LASTS = 30;
   localparam int unsigned BIT_FIRST = 29;
   localparam int unsigned BIT_LINK  = 24;
   localparam int unsigned STS_LO_W  = 17;
   localparam int unsigned DESC_SPAN = 16;

   typedef enum logic [2:0] {
      ST_STOP,
      ST_DESC,
      ST_BUFWAIT,
      ST_BUFRD,
      ST_WBACK,
      ST_NEXT,
      ST_SUSP
   } walk_state_t;
endpackage

// File: rtl/txd_regfile.sv
module txd_regfile import txd_pkg::*; #(
   parameter int unsigned REG_AW = 8,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              run_o,
   output logic [ADDR_W-1:0] list_base_o,
   output logic              base_load_o,
   output logic [ADDR_W-1:0] base_val_o,
   output logic              poll_o,
   output logic              srst_o
);
   logic hit_bus, hit_poll, hit_base, hit_oper;
   wire  unused_wdata = ^reg_wdata;

   assign hit_bus  = reg_wr && (reg_addr == REG_AW'(OFS_BUS));
   assign hit_poll = reg_wr && (reg_addr == REG_AW'(OFS_POLL));
   assign hit_base = reg_wr && (reg_addr == REG_AW'(OFS_BASE));
   assign hit_oper = reg_wr && (reg_addr == REG_AW'(OFS_OPER));

   assign srst_o      = hit_bus && reg_wdata[BIT_SRST];
   assign poll_o      = hit_poll;
   assign base_load_o = hit_base;
   assign base_val_o  = {reg_wdata[ADDR_W-1:2], 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o       <= 1'b0;
         list_base_o <= '0;
      end else begin
         if (srst_o)
            run_o <= 1'b0;
         else if (hit_oper)
            run_o <= reg_wdata[BIT_RUN];
         if (hit_base)
            list_base_o <= base_val_o;
      end
   end
endmodule

// File: rtl/txd_lanes.sv
module txd_lanes #(
   parameter  int unsigned WORD_BYTES = 4,
   localparam int unsigned LANE_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
   localparam int unsigned CNT_LW = $clog2(WORD_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush_i,
   input  logic                    load_i,
   input  logic [8*WORD_BYTES-1:0] word_i,
   input  logic [LANE_W-1:0]       first_lane_i,
   input  logic [CNT_LW-1:0]       nbytes_i,
   input  logic                    sof_i,
   input  logic                    eof_i,
   input  logic                    out_ready_i,
   output logic                    out_valid_o,
   output logic [7:0]              out_data_o,
   output logic                    out_sof_o,
   output logic                    out_eof_o,
   output logic                    idle_o
);
   logic [8*WORD_BYTES-1:0] hold_q;
   logic [LANE_W-1:0]       lane_q;
   logic [CNT_LW-1:0]       rem_q;
   logic                    sof_q, eof_q;

   generate
      if (WORD_BYTES == 1) begin : g_single
         wire unused_lane = ^lane_q;
         assign out_data_o = hold_q[7:0];
      end else begin : g_mux
         logic [7:0] byte_a [WORD_BYTES];
         for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
            assign byte_a[g] = hold_q[8*g +: 8];
         end
         assign out_data_o = byte_a[lane_q];
      end
   endgenerate

   assign out_valid_o = (rem_q != '0);
   assign idle_o      = (rem_q == '0);
   assign out_sof_o   = sof_q;
   assign out_eof_o   = eof_q && (rem_q == CNT_LW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         lane_q <= '0;
         rem_q  <= '0;
         sof_q  <= 1'b0;
         eof_q  <= 1'b0;
      end else if (flush_i) begin
         rem_q <= '0;
         sof_q <= 1'b0;
         eof_q <= 1'b0;
      end else if (load_i) begin
         hold_q <= word_i;
         lane_q <= first_lane_i;
         rem_q  <= nbytes_i;
         sof_q  <= sof_i;
         eof_q  <= eof_i;
      end else if (out_valid_o && out_ready_i) begin
         lane_q <= lane_q + LANE_W'(1);
         rem_q  <= rem_q - CNT_LW'(1);
         sof_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/txd_walker.sv
module txd_walker import txd_pkg::*; #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              poll_i,
   input  logic              srst_i,
   input  logic              base_load_i,
   input  logic [ADDR_W-1:0] base_val_i,
   input  logic [ADDR_W-1:0] list_base_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              lane_load_o,
   output logic [31:0]       lane_word_o,
   output logic [1:0]        lane_first_o,
   output logic [2:0]        lane_nbytes_o,
   output logic              lane_sof_o,
   output logic              lane_eof_o,
   input  logic              lane_idle_i,
   output logic              unavail_o
);
   localparam int unsigned KEEP_W = WORD_W - 1 - STS_LO_W;

   walk_state_t       st_q;
   logic [ADDR_W-1:0] cur_q, next_q, byte_addr_q;
   logic [1:0]        widx_q;
   logic [KEEP_W-1:0] keep_q;
   logic [CNT_W-1:0]  left_q;
   logic              first_q, last_q, link_q, chunk0_q;
   logic [2:0]        avail, take;
   logic [ADDR_W-1:0] nxt_ptr;

   assign avail   = 3'd4 - {1'b0, byte_addr_q[1:0]};
   assign take    = (left_q < CNT_W'(avail)) ? 3'(left_q) : avail;
   assign nxt_ptr = link_q ? next_q : cur_q + ADDR_W'(DESC_SPAN);

   assign lane_load_o   = (st_q == ST_BUFRD) && mem_ack_i;
   assign lane_word_o   = mem_rdata_i;
   assign lane_first_o  = byte_addr_q[1:0];
   assign lane_nbytes_o = take;
   assign lane_sof_o    = first_q && chunk0_q;
   assign lane_eof_o    = last_q && (left_q == CNT_W'(take));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_STOP;
         cur_q       <= '0;
         next_q      <= '0;
         byte_addr_q <= '0;
         widx_q      <= '0;
         keep_q      <= '0;
         left_q      <= '0;
         first_q     <= 1'b0;
         last_q      <= 1'b0;
         link_q      <= 1'b0;
         chunk0_q    <= 1'b0;
         unavail_o   <= 1'b0;
         mem_req_o   <= 1'b0;
         mem_we_o    <= 1'b0;
         mem_addr_o  <= '0;
         mem_wdata_o <= '0;
      end else if (srst_i) begin
         st_q      <= ST_STOP;
         cur_q     <= list_base_i;
         unavail_o <= 1'b0;
         mem_req_o <= 1'b0;
         mem_we_o  <= 1'b0;
      end else begin
         case (st_q)
            ST_STOP: begin
               if (base_load_i)
                  cur_q <= base_val_i;
               else if (run_i) begin
                  st_q       <= ST_DESC;
                  widx_q     <= '0;
                  mem_req_o  <= 1'b1;
                  mem_we_o   <= 1'b0;
                  mem_addr_o <= cur_q;
               end
            end
            ST_DESC: if (mem_ack_i) begin
               case (widx_q)
                  2'd0: keep_q <= mem_rdata_i[WORD_W-2:STS_LO_W];
                  2'd1: begin
                     left_q   <= mem_rdata_i[CNT_W-1:0];
                     first_q  <= mem_rdata_i[BIT_FIRST];
                     last_q   <= mem_rdata_i[BIT_LASTS];
                     link_q   <= mem_rdata_i[BIT_LINK];
                     chunk0_q <= 1'b1;
                  end
                  2'd2: byte_addr_q <= mem_rdata_i[ADDR_W-1:0];
                  default: next_q <= mem_rdata_i[ADDR_W-1:0];
               endcase
               if (widx_q == 2'd0 && !mem_rdata_i[BIT_OWN]) begin
                  st_q      <= ST_SUSP;
                  unavail_o <= 1'b1;
                  mem_req_o <= 1'b0;
               end else if (widx_q == 2'd3) begin
                  st_q      <= ST_BUFWAIT;
                  mem_req_o <= 1'b0;
               end else begin
                  widx_q     <= widx_q + 2'd1;
                  mem_addr_o <= cur_q + ADDR_W'({widx_q + 2'd1, 2'b00});
               end
            end
            ST_BUFWAIT: if (lane_idle_i) begin
               mem_req_o <= 1'b1;
               if (left_q == '0) begin
                  st_q        <= ST_WBACK;
                  mem_we_o    <= 1'b1;
                  mem_addr_o  <= cur_q;
                  mem_wdata_o <= {1'b0, keep_q, {STS_LO_W{1'b0}}};
               end else begin
                  st_q       <= ST_BUFRD;
                  mem_we_o   <= 1'b0;
                  mem_addr_o <= {byte_addr_q[ADDR_W-1:2], 2'b00};
               end
            end
            ST_BUFRD: if (mem_ack_i) begin
               mem_req_o   <= 1'b0;
               byte_addr_q <= byte_addr_q + ADDR_W'(take);
               left_q      <= left_q - CNT_W'(take);
               chunk0_q    <= 1'b0;
               st_q        <= ST_BUFWAIT;
            end
            ST_WBACK: if (mem_ack_i) begin
               mem_req_o <= 1'b0;
               mem_we_o  <= 1'b0;
               st_q      <= ST_NEXT;
            end
            ST_NEXT: begin
               cur_q <= nxt_ptr;
               if (run_i) begin
                  st_q       <= ST_DESC;
                  widx_q     <= '0;
                  mem_req_o  <= 1'b1;
                  mem_addr_o <= nxt_ptr;
               end else
                  st_q <= ST_STOP;
            end
            ST_SUSP: begin
               if (!run_i)
                  st_q <= ST_STOP;
               else if (poll_i) begin
                  st_q       <= ST_DESC;
                  widx_q     <= '0;
                  mem_req_o  <= 1'b1;
                  mem_we_o   <= 1'b0;
                  mem_addr_o <= cur_q;
               end
            end
            default: st_q <= ST_STOP;
         endcase
      end
   end
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma import txd_pkg::*; #(
   parameter int unsigned REG_AW = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_sof,
   output logic              tx_eof,
   output logic              tx_unavail
);
   localparam int unsigned WORD_BYTES = WORD_W / 8;

   generate
      if (CNT_W < 3 || CNT_W > 16) begin : g_bad_cnt
         $error("txdesc_dma: CNT_W must lie in 3..16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("txdesc_dma: ADDR_W must lie in 8..32");
      end
      if (REG_AW < 5) begin : g_bad_reg
         $error("txdesc_dma: REG_AW must reach offset 0x18");
      end
   endgenerate

   logic              run, base_load, poll, srst;
   logic [ADDR_W-1:0] list_base, base_val;
   logic              lane_load, lane_sof, lane_eof, lane_idle;
   logic [31:0]       lane_word;
   logic [1:0]        lane_first;
   logic [2:0]        lane_nbytes;

   txd_regfile #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .run_o(run), .list_base_o(list_base),
      .base_load_o(base_load), .base_val_o(base_val), .poll_o(poll),
      .srst_o(srst)
   );

   txd_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) walk_i (
      .clk(clk), .rst_n(rst_n), .run_i(run), .poll_i(poll), .srst_i(srst),
      .base_load_i(base_load), .base_val_i(base_val), .list_base_i(list_base),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .lane_load_o(lane_load), .lane_word_o(lane_word),
      .lane_first_o(lane_first), .lane_nbytes_o(lane_nbytes),
      .lane_sof_o(lane_sof), .lane_eof_o(lane_eof),
      .lane_idle_i(lane_idle), .unavail_o(tx_unavail)
   );

   txd_lanes #(.WORD_BYTES(WORD_BYTES)) lanes_i (
      .clk(clk), .rst_n(rst_n), .flush_i(srst), .load_i(lane_load),
      .word_i(lane_word), .first_lane_i(lane_first), .nbytes_i(lane_nbytes),
      .sof_i(lane_sof), .eof_i(lane_eof), .out_ready_i(tx_ready),
      .out_valid_o(tx_valid), .out_data_o(tx_data), .out_sof_o(tx_sof),
      .out_eof_o(tx_eof), .idle_o(lane_idle)
   );
endmodule

// File: rtl/txd_checker.sv
module txd_checker #(
   parameter int unsigned REG_AW = 8,
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_ack,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [7:0]        tx_data,
   input logic              tx_sof,
   input logic              tx_eof,
   input logic              tx_unavail
);
   logic srst_now;
   wire  unused_wd = ^reg_wdata;
   assign srst_now = reg_wr && (reg_addr == '0) && reg_wdata[0];

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack && !srst_now |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !srst_now |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)); // R7
   AST_WB_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[31] && (mem_wdata[16:0] == 17'd0)); // R8
   AST_WB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !tx_valid); // R8
   AST_UNAVAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_unavail && !srst_now |=> tx_unavail); // R3
   AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      srst_now |=> !tx_valid && !mem_req && !tx_unavail); // R11
endmodule

bind txdesc_dma txd_checker #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
   .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_unavail(tx_unavail)
);

// File: tb/txdesc_dma_tb_top.sv
`timescale 1ns/1ps
module txdesc_dma_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        tx_valid, tx_sof, tx_eof, tx_unavail;
   logic        tx_ready = 1'b0;
   logic [7:0]  tx_data;

   int n_cmp = 0;
   int n_bad = 0;
   int wr_count = 0;
   bit ready_rand = 1'b0;
   bit finished = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   logic [9:0]  expq [$];
   logic [31:0] mem [0:1023];

   always #2 clk = ~clk;

   txdesc_dma dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
      .tx_unavail(tx_unavail)
   );

   // memory model: one acknowledge per request, a cycle later
   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            wr_count <= wr_count + 1;
         end else
            mem_rdata <= mem[mem_addr[11:2]];
      end else
         mem_ack <= 1'b0;
   end

   function automatic logic [7:0] pat(int a);
      return 8'((a * 13 + 7) ^ (a >> 8));
   endfunction

   task automatic ck(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
      end
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // monitor: new ready at the falling edge, handshake sampled just after
   initial begin
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tx_ready = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
         #1;
         if (rst_n && tx_valid && tx_ready) begin
            if (expq.size() == 0)
               ck(1'b0, "R3 R9 unexpected byte", {22'd0, tx_sof, tx_eof, tx_data}, 32'h0);
            else begin
               logic [9:0] e;
               e = expq.pop_front();
               ck({tx_sof, tx_eof, tx_data} == e, "R5 R6 byte/marker",
                  {22'd0, tx_sof, tx_eof, tx_data}, {22'd0, e});
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      report();
   end

   task automatic reg_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // control word: bit30 last, bit29 first, bit24 link, bits10:0 count
   task automatic put_desc(int a, bit own, bit fst, bit lst, bit lnk, int cnt,
                           int bufa, int nxt, logic [30:0] sts);
      mem[a >> 2]       = {own, sts};
      mem[(a >> 2) + 1] = {1'b0, lst, fst, 4'b0, lnk, 13'b0, 11'(cnt)};
      mem[(a >> 2) + 2] = 32'(bufa);
      mem[(a >> 2) + 3] = 32'(nxt);
   endtask

   task automatic expect_bytes(int bufa, int cnt, bit fst, bit lst);
      for (int i = 0; i < cnt; i++)
         expq.push_back({(i == 0) && fst, (i == cnt - 1) && lst, pat(bufa + i)});
   endtask

   task automatic settle(string rq);
      int t = 0;
      while (expq.size() != 0 && t < 20000) begin
         @(negedge clk);
         t++;
      end
      ck(expq.size() == 0, rq, 32'(expq.size()), 32'd0);
      repeat (30) @(negedge clk);
   endtask

   task automatic quiet(int n, string rq);
      bit seen = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (mem_req) seen = 1'b1;
      end
      ck(!seen, rq, 32'(seen), 32'd0);
   endtask

   localparam logic [31:0] KEEP = 32'h7FFE_0000;

   initial begin
      logic [31:0] sA;
      for (int w = 0; w < 1024; w++)
         mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      repeat (5) @(negedge clk);
      // R1 reset state
      ck(!tx_valid && !mem_req && !tx_unavail, "R1 reset outputs",
         {29'd0, tx_valid, mem_req, tx_unavail}, 32'd0);
      rst_n = 1'b1;
      quiet(5, "R1 idle after reset");

      // R2 R5 R6 R8 R9: single owned frame, then host-owned link target
      sA = {1'b1, 14'h2AAA, 17'h1ABCD};
      put_desc('h100, 1, 1, 1, 1, 5, 'h200, 'h140, sA[30:0]);
      put_desc('h140, 0, 0, 0, 0, 0, 0, 0, 31'h0);
      expect_bytes('h200, 5, 1, 1);
      reg_write(8'h10, 32'h100);
      reg_write(8'h18, 32'h2000);
      settle("R2 R5 first frame drained");
      ck(mem['h100 >> 2] == (sA & KEEP), "R8 write-back value", mem['h100 >> 2], sA & KEEP);
      ck(wr_count == 1, "R8 single write", 32'(wr_count), 32'd1);
      ck(tx_unavail == 1'b1, "R3 unavailable flag", 32'(tx_unavail), 32'd1);

      // R4 R6 R7 R9: two-segment frame, unaligned buffers, stalled sink
      put_desc('h140, 1, 1, 0, 1, 7, 'h303, 'h180, 31'h0155_0003);
      put_desc('h180, 1, 0, 1, 0, 3, 'h3F1, 'h1F0, 31'h0);
      put_desc('h190, 0, 0, 0, 0, 0, 0, 0, 31'h0);
      put_desc('h1F0, 1, 1, 1, 0, 1, 'h600, 'h100, 31'h0);
      expect_bytes('h303, 7, 1, 0);
      expect_bytes('h3F1, 3, 0, 1);
      ready_rand = 1'b1;
      reg_write(8'h04, 32'h0);
      settle("R4 poll resumes transfer");
      ck(mem['h140 >> 2] == 32'h0154_0000, "R8 write-back first segment",
         mem['h140 >> 2], 32'h0154_0000);
      ck(mem['h180 >> 2] == 32'h0, "R8 write-back last segment", mem['h180 >> 2], 32'h0);
      ck(mem['h1F0 >> 2][31] == 1'b1, "R9 sequential step skips link", mem['h1F0 >> 2], 32'h8000_0000);
      ck(wr_count == 3, "R8 write count", 32'(wr_count), 32'd3);
      ck(tx_unavail == 1'b1, "R3 flag sticky across resume", 32'(tx_unavail), 32'd1);

      // R5 zero byte count
      put_desc('h190, 1, 1, 1, 1, 0, 'h700, 'h1A0, 31'h7FFF_FFFF);
      put_desc('h1A0, 0, 0, 0, 0, 0, 0, 0, 31'h0);
      reg_write(8'h04, 32'hFFFF_FFFF);
      settle("R5 zero count");
      ck(mem['h190 >> 2] == 32'h7FFE_0000, "R5 zero count still written back",
         mem['h190 >> 2], 32'h7FFE_0000);
      ck(wr_count == 4, "R5 zero count write", 32'(wr_count), 32'd4);

      // R12 run cleared while parked: poll ignored, restart at current pointer
      reg_write(8'h18, 32'h0);
      reg_write(8'h04, 32'h0);
      quiet(12, "R12 no fetch while run is 0");
      put_desc('h1A0, 1, 1, 1, 1, 2047, 'h801, 'h1C0, 31'h0);
      put_desc('h1C0, 0, 0, 0, 0, 0, 0, 0, 31'h0);
      expect_bytes('h801, 2047, 1, 1);
      reg_write(8'h18, 32'h2000);
      settle("R12 R5 restart at current pointer, max count");
      ck(mem['h1A0 >> 2] == 32'h0, "R8 write-back max count", mem['h1A0 >> 2], 32'h0);
      ck(wr_count == 5, "R12 write count", 32'(wr_count), 32'd5);

      // R11 soft reset: base write while active, then reset
      reg_write(8'h10, 32'h140);
      reg_write(8'h00, 32'h1);
      ck(!tx_unavail && !mem_req && !tx_valid, "R11 reset clears flag",
         {29'd0, tx_unavail, mem_req, tx_valid}, 32'd0);
      quiet(12, "R11 run cleared by soft reset");
      put_desc('h140, 1, 1, 1, 1, 4, 'h500, 'h100, 31'h0);
      expect_bytes('h500, 4, 1, 1);
      reg_write(8'h18, 32'h2000);
      settle("R11 restart at list base");
      ck(mem['h140 >> 2] == 32'h0, "R11 write-back at base", mem['h140 >> 2], 32'h0);
      ck(wr_count == 6, "R11 write count", 32'(wr_count), 32'd6);
      ck(tx_unavail == 1'b1, "R3 flag raised again", 32'(tx_unavail), 32'd1);
      ck(expq.size() == 0, "R5 scoreboard empty", 32'(expq.size()), 32'd0);
      report();
   end
endmodule